// File: doc/BRIEF.md
# Interlaced frame reset generator

This block derives a single frame-start pulse from the horizontal and vertical sync of an interlaced picture. Both sync inputs arrive asynchronously. Each is brought into the pixel clock domain through a two-stage synchronizer and then passed through a polarity selector. The vertical sync is reduced to a one-clock pulse on each rising edge. A pixel counter restarts on every horizontal sync rising edge, and its count is compared against a pair of bounds to form a half-line window with a 50:50 duty cycle.

A vertical edge that lands inside the high half of the window produces the frame reset. In one field the vertical sync arrives in the first half of a line, and in the other field it arrives in the second half. Only one of the two fields therefore produces a pulse.

Real lines can run longer or shorter than the nominal 768 pixels. A vertical sync that lands close to a window boundary could then be missed in both fields, or accepted in both. To prevent this, a 4-bit alignment value shifts the whole window later in steps of 12 clocks, so the window can be placed well away from both vertical arrival points.

Top module: `frame_reset_gen`

## Requirements
- R1: With `hpol_i`/`vpol_i` at 0 the matching sync input is active high. With the bit at 1 the input is inverted before synchronization and edge detection, so a falling raw edge counts as the active rising edge.
- R2: A change on a raw sync input takes effect only after two synchronizer flops. For a horizontal edge driven before clock edge H, `count_o` reads 0 after clock edge H+2.
- R3: After the horizontal restart, `count_o` increases by one on every clock.
- R4: `count_o` saturates at 1023 and does not wrap. It stays at 1023 until the next horizontal sync rising edge.
- R5: With alignment value N on `align_i`, `window_o` is high exactly when 12*N <= `count_o` < 384+12*N. With N = 0 the window therefore covers counts 0 through 383.
- R6: The alignment value shifts both window boundaries together. The window always spans 384 counts unless the line is cut short by a new horizontal sync.
- R7: `frame_rst_o` is a registered AND of the vertical rising-edge pulse and the window. For a vertical edge driven before clock edge V, the pulse is high for exactly the one clock after edge V+2. It is high only if `window_o` was high while `count_o` held the value it had after edge V+1.
- R8: In reset and just after it, `frame_rst_o` = 0, `window_o` = 0 and `count_o` = 1023, meaning no line has been seen yet. Leaving reset creates no spurious edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| vsync_in | input | 1 | Raw vertical sync, asynchronous |
| hpol_i | input | 1 | 1 inverts the horizontal sync |
| vpol_i | input | 1 | 1 inverts the vertical sync |
| align_i | input | 4 | Window shift in units of 12 clocks |
| frame_rst_o | output | 1 | One-clock frame reset pulse |
| window_o | output | 1 | Half-line window |
| count_o | output | 10 | Pixel count since the last horizontal sync |

## Verification
The bench places a vertical edge at exact clock offsets from the horizontal edge. The targeted cases are the last count inside each window boundary and the first count outside it, both at zero alignment and at the largest alignment. A design whose comparator is off by one, or whose shift uses the wrong step, would accept or reject the edge on the wrong side of the boundary.

Inverted polarities are mixed in at random. A missed inversion turns the falling raw edge into no pulse, or fires the pulse at the wrong time. A very long line checks that the count holds at 1023 with the window closed, where a wrapping counter would reopen the window. The pulse is also checked on the clocks before and after its expected slot, which catches a lost synchronizer stage and a pulse more than one clock wide.

// File: rtl/frst_pkg.sv
package frst_pkg;

    localparam int CNT_W      = 10;
    localparam int ALIGN_W    = 4;
    localparam int HALF_LINE  = 384;
    localparam int ALIGN_STEP = 12;
    localparam int SYNC_DEPTH = 2;
    localparam int N_CHAN     = 2;

    typedef enum logic [0:0] {
        CH_HORIZ = 1'b0,
        CH_VERT  = 1'b1
    } chan_e;

    // Conditioned sync channel: level after polarity, plus rising-edge pulse
    typedef struct packed {
        logic level;
        logic rise;
    } sync_sig_t;

    typedef struct packed {
        logic [CNT_W:0] open_at;
        logic [CNT_W:0] close_at;
    } win_bounds_t;

    function automatic win_bounds_t calc_bounds(input logic [ALIGN_W-1:0] align);
        win_bounds_t b;
        logic [CNT_W:0] shift;
        shift      = (CNT_W+1)'(align) * (CNT_W+1)'(ALIGN_STEP);
        b.open_at  = shift;
        b.close_at = shift + (CNT_W+1)'(HALF_LINE);
        return b;
    endfunction

endpackage

// File: rtl/frst_sync_edge.sv
module frst_sync_edge
    import frst_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    input  logic      invert_i,
    output sync_sig_t sig_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= raw_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1] ^ invert_i;

    // previous level starts high so that leaving reset never looks like an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end

    always_comb begin
        sig_o.level = level;
        sig_o.rise  = level & ~prev_q;
    end

endmodule

// File: rtl/frst_line_counter.sv
module frst_line_counter
    import frst_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TOP;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/frst_half_window.sv
module frst_half_window
    import frst_pkg::*;
#(
    parameter int WIDTH = CNT_W,
    parameter int AW    = ALIGN_W
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic [AW-1:0]    align_i,
    output logic             window_o
);

    win_bounds_t    bounds;
    logic [CNT_W:0] cnt_ext;

    always_comb begin
        bounds   = calc_bounds(ALIGN_W'(align_i));
        cnt_ext  = (CNT_W+1)'(count_i);
        window_o = (cnt_ext >= bounds.open_at) && (cnt_ext < bounds.close_at);
    end

endmodule

// File: rtl/frame_reset_gen.sv
module frame_reset_gen
    import frst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hsync_in,
    input  logic               vsync_in,
    input  logic               hpol_i,
    input  logic               vpol_i,
    input  logic [ALIGN_W-1:0] align_i,
    output logic               frame_rst_o,
    output logic               window_o,
    output logic [CNT_W-1:0]   count_o
);

    logic      raw_vec [N_CHAN];
    logic      inv_vec [N_CHAN];
    sync_sig_t chan_sig[N_CHAN];

    logic h_rise;
    logic v_rise;
    logic win;
    logic frame_q;

    always_comb begin
        raw_vec[CH_HORIZ] = hsync_in;
        raw_vec[CH_VERT]  = vsync_in;
        inv_vec[CH_HORIZ] = hpol_i;
        inv_vec[CH_VERT]  = vpol_i;
    end

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            frst_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
                .clk      (clk),
                .rst      (rst),
                .raw_i    (raw_vec[c]),
                .invert_i (inv_vec[c]),
                .sig_o    (chan_sig[c])
            );
        end
    endgenerate

    assign h_rise = chan_sig[CH_HORIZ].rise;
    assign v_rise = chan_sig[CH_VERT].rise;

    frst_line_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart_i (h_rise),
        .count_o   (count_o)
    );

    frst_half_window #(.WIDTH(CNT_W), .AW(ALIGN_W)) u_win (
        .count_i  (count_o),
        .align_i  (align_i),
        .window_o (win)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_q <= 1'b0;
        else     frame_q <= v_rise & win;
    end

    assign frame_rst_o = frame_q;
    assign window_o    = win;

endmodule

// File: rtl/frst_checker.sv
module frst_checker
    import frst_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               h_rise,
    input logic               frame_rst_o,
    input logic               window_o,
    input logic [CNT_W-1:0]   count_o,
    input logic [ALIGN_W-1:0] align_i
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        frame_rst_o |=> !frame_rst_o);

    // R7
    pulse_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        frame_rst_o |-> $past(window_o));

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        h_rise |=> (count_o == '0));

    // R4
    saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count_o == TOP && !h_rise) |=> (count_o == TOP));

    // R6
    close_point_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(window_o) && $stable(align_i) && !$past(h_rise))
        |-> (int'(count_o) == HALF_LINE + ALIGN_STEP * int'(align_i)));

endmodule

bind frame_reset_gen frst_checker u_frst_checker (
    .clk         (clk),
    .rst         (rst),
    .h_rise      (h_rise),
    .frame_rst_o (frame_rst_o),
    .window_o    (window_o),
    .count_o     (count_o),
    .align_i     (align_i)
);

// File: tb/frame_reset_gen_test.sv
module frame_reset_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0;
    logic       vsync_in = 1'b0;
    logic       hpol_i = 1'b0;
    logic       vpol_i = 1'b0;
    logic [3:0] align_i = 4'd0;
    logic       frame_rst_o;
    logic       window_o;
    logic [9:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_reset_gen uut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hpol_i(hpol_i), .vpol_i(vpol_i), .align_i(align_i),
        .frame_rst_o(frame_rst_o), .window_o(window_o), .count_o(count_o)
    );

    function automatic int exp_count(int since);
        return (since > 1023) ? 1023 : since;
    endfunction

    function automatic bit exp_win(int cnt, int n);
        return (cnt >= 12*n) && (cnt < 384 + 12*n);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Horizontal edge, then vertical edge d negedges later (d >= 4).
    task automatic trial(int n, bit hp, bit vp, int d);
        int ev;
        align_i  = 4'(n);
        hpol_i   = hp;
        vpol_i   = vp;
        hsync_in = hp;
        vsync_in = vp;
        repeat (6) @(negedge clk);
        hsync_in = ~hp;
        ev = exp_win(exp_count(d-1), n);
        for (int j = 1; j <= d + 4; j++) begin
            @(negedge clk);
            if (j == 2) hsync_in = hp;
            if (j == 3) begin
                // R2 R1: count restarted after two synchronizer stages
                chk(count_o == 10'd0, "R2", count_o, 0);
                chk(window_o == exp_win(0, n), "R5", window_o, exp_win(0, n));
            end
            if (j == d) begin
                // R3 R4: counting and saturation
                chk(int'(count_o) == exp_count(d-3), "R3", count_o, exp_count(d-3));
                // R6: window placement for this alignment
                chk(window_o == exp_win(exp_count(d-3), n), "R6", window_o,
                    exp_win(exp_count(d-3), n));
                vsync_in = ~vp;
            end
            if (j == d + 2) begin
                vsync_in = vp;
                chk(frame_rst_o == 1'b0, "R7", frame_rst_o, 0);
            end
            if (j == d + 3)
                chk(frame_rst_o == ev[0], "R7", frame_rst_o, ev);
            if (j == d + 4)
                chk(frame_rst_o == 1'b0, "R7", frame_rst_o, 0);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(frame_rst_o == 1'b0, "R8", frame_rst_o, 0);
        chk(window_o == 1'b0, "R8", window_o, 0);
        chk(count_o == 10'd1023, "R8", count_o, 1023);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R8: no spurious restart when leaving reset
        chk(count_o == 10'd1023, "R8", count_o, 1023);
        chk(frame_rst_o == 1'b0, "R8", frame_rst_o, 0);

        // R5: boundaries at zero alignment
        trial(0, 1'b0, 1'b0, 384);
        trial(0, 1'b0, 1'b0, 385);
        trial(0, 1'b0, 1'b0, 4);
        // R6: boundaries at largest alignment
        trial(15, 1'b0, 1'b0, 180);
        trial(15, 1'b0, 1'b0, 181);
        trial(15, 1'b0, 1'b0, 564);
        trial(15, 1'b0, 1'b0, 565);
        // R1: inverted polarities
        trial(3, 1'b1, 1'b0, 100);
        trial(3, 1'b0, 1'b1, 100);
        trial(3, 1'b1, 1'b1, 500);
        // R4: long line saturates, window stays closed
        trial(0, 1'b0, 1'b0, 1100);
        chk(count_o == 10'd1023, "R4", count_o, 1023);

        // random mix of alignments, polarities and vertical offsets
        for (int t = 0; t < 40; t++) begin
            int n, d;
            bit hp, vp;
            n  = int'($urandom_range(15, 0));
            hp = 1'($urandom_range(1, 0));
            vp = 1'($urandom_range(1, 0));
            d  = int'($urandom_range(700, 4));
            trial(n, hp, vp, d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule